// File: doc/BRIEF.md
# Linkable Dual 8-Bit Compare Timer

The block holds two 8-bit up-counters, each with two compare registers (A and B), a clock-select field, a clear-select field, two sticky compare flags and one output pin. Each pin can be driven low, driven high or toggled on a compare event. A small register port writes and reads every register.

A reserved clock-select code, 3'b100, joins the two channels. If channel 0 carries the code, the counters form one 16-bit counter. Channel 0 is the high byte and channel 1 is the low byte. In this mode channel 0 watches the full 16-bit compare, and channel 1 watches only the low byte. If only channel 1 carries the code, counter 1 counts channel 0's compare-A events. Both channels otherwise keep their own settings.

A bus master configures the channels and provides two prescaled count strobes (`tick_i`). It services the flags by reading a flag as 1 and then writing 0 to it.

Top module: `tmr_pair_top`

## Requirements
- R1: After an active-low reset, every register reads 0 and both pins are low.
- R2: Clock-select field `ctrl[2:0]` selects how the channel counts:
  - 000: the channel stops.
  - 001: it counts on `tick_i[0]`.
  - 010: it counts on `tick_i[1]`.
  - 011: it counts every clock.
  - The counter adds one per enabled cycle and wraps past 8'hFF.
- R3: A compare event occurs in the first cycle in which a counter equals a compare register. The matching flag sets at the following edge. The flags are status bit 6 (A) and bit 7 (B).
- R4: A flag stays set until a status write with 0 in its bit. That write clears the flag only if a status read (`rd_en_i`) has seen the flag as 1 since the previous status write. Writing without a prior read has no effect.
- R5: Clear-select field `ctrl[4:3]` picks when the counter returns to 0:
  - 00: never.
  - 01: on a compare-A event.
  - 10: on a compare-B event.
  - 11: on either event.
  - Separately, when `ctrl[5]` is set, `ext_clr_i` high clears the counter.
  - A clear takes effect at the edge that ends the event cycle.
- R6: Status `[1:0]` is the action on compare-A events and `[3:2]` the action on compare-B events. The codes are 00 none, 01 low, 10 high and 11 toggle. When A and B events occur together, the A action is applied.
- R7: Clock-select 100 on channel 0 selects 16-bit mode. The value is {count0, count1}, it advances on `tick_i[0]`, the low byte carries into the high byte, and 16'hFFFF wraps to 0.
- R8: In 16-bit mode, channel 0's flags set on 16-bit events against {cmp0, cmp1}. Channel 1's flags set on low-byte events.
- R9: In 16-bit mode, channel 0's clear settings clear both bytes on a 16-bit event, even with `ext_clr_i` clear also enabled. Channel 1's clear fields are ignored, and the low byte is never cleared alone.
- R10: In 16-bit mode, pin 0 follows channel 0's actions on 16-bit events. Pin 1 follows channel 1's actions on low-byte events.
- R11: With code 100 on channel 1 only, counter 1 adds one on each channel-0 compare-A event. Each channel applies its own flag, clear and pin settings.
- R12: A count register write sets that byte at the next edge, ahead of counting and clearing. The address is `{channel, register}`, with register codes 0 control, 1 status, 2 count, 3 compare A and 4 compare B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 2 | Prescaled count strobes |
| ext_clr_i | input | 1 | External counter clear request |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address {channel, register} |
| wr_data_i | input | CNT_W | Write data |
| rd_en_i | input | 1 | Read strobe; arms flag clearing |
| rd_addr_i | input | 4 | Read address {channel, register} |
| rd_data_o | output | CNT_W | Read data, combinational |
| pin_o | output | 2 | Compare output pins, one per channel |

## Verification
The assertions check four properties on every cycle:
- A pin changes only alongside a set flag of its channel.
- A set flag survives every cycle without a status write.
- A stopped counter only holds or clears.
- In 16-bit mode the low byte never drops to zero alone, and in compare-count mode counter 1 never steps without a channel-0 compare-A flag.

The bench scenarios show the rest:
- exact count values and the carry and wrap of the 16-bit counter;
- the ignored channel-1 clear;
- A-over-B pin priority;
- the read-then-write flag protocol;
- counting of channel-0 compare events.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned N_CH  = 2;
  localparam int unsigned SEL_W = 3;

  localparam logic [2:0] CS_STOP  = 3'b000;
  localparam logic [2:0] CS_TICK0 = 3'b001;
  localparam logic [2:0] CS_TICK1 = 3'b010;
  localparam logic [2:0] CS_EVERY = 3'b011;
  localparam logic [2:0] CS_LINK  = 3'b100;

  localparam logic [SEL_W-1:0] RG_CTRL = 3'd0;
  localparam logic [SEL_W-1:0] RG_STAT = 3'd1;
  localparam logic [SEL_W-1:0] RG_CNT  = 3'd2;
  localparam logic [SEL_W-1:0] RG_CMPA = 3'd3;
  localparam logic [SEL_W-1:0] RG_CMPB = 3'd4;

  localparam int unsigned FLAG_LSB = 6;

  typedef struct packed {
    logic       ext_en;
    logic [1:0] clr_sel;
    logic [2:0] clk_sel;
  } ctrl_t;

  typedef struct packed {
    logic [1:0] act_b;
    logic [1:0] act_a;
  } act_t;

  function automatic logic sel_tick(input logic [2:0] cs, input logic [1:0] tk);
    logic r;
    unique case (cs)
      CS_TICK0: r = tk[0];
      CS_TICK1: r = tk[1];
      CS_EVERY: r = 1'b1;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic clr_hit(input ctrl_t cr, input logic ha, input logic hb,
                                   input logic ext);
    logic r;
    unique case (cr.clr_sel)
      2'b01:   r = ha;
      2'b10:   r = hb;
      2'b11:   r = ha | hb;
      default: r = 1'b0;
    endcase
    return r | (cr.ext_en & ext);
  endfunction

  function automatic logic pin_next(input logic cur, input logic [1:0] act);
    logic r;
    unique case (act)
      2'b01:   r = 1'b0;
      2'b10:   r = 1'b1;
      2'b11:   r = ~cur;
      default: r = cur;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tmr_cmp.sv
module tmr_cmp #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] ref_i,
  output logic         hit_o
);
  logic eq, eq_q;

  assign eq = (val_i == ref_i);

  // eq_q resets high so a reset counter does not fire on equal reset values
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eq_q <= 1'b1;
    else         eq_q <= eq;
  end

  assign hit_o = eq & ~eq_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             set_a_i,
  input  logic             set_b_i,
  output ctrl_t            ctrl_o,
  output act_t             act_o,
  output logic [CNT_W-1:0] cmp_a_o,
  output logic [CNT_W-1:0] cmp_b_o,
  output logic             flag_a_o,
  output logic             flag_b_o,
  output logic [CNT_W-1:0] rd_data_o
);
  localparam int unsigned NF = 2;

  logic [NF-1:0] flag_q, arm_q, set_v, wbit;
  logic          wr_stat, rd_stat;

  assign wr_stat = wr_en_i && (wr_sel_i == RG_STAT);
  assign rd_stat = rd_en_i && (rd_sel_i == RG_STAT);
  assign set_v   = {set_b_i, set_a_i};
  assign wbit    = wr_data_i[FLAG_LSB +: NF];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= '0;
      act_o   <= '0;
      cmp_a_o <= '0;
      cmp_b_o <= '0;
    end else if (wr_en_i) begin
      unique case (wr_sel_i)
        RG_CTRL: ctrl_o  <= ctrl_t'(wr_data_i[5:0]);
        RG_STAT: act_o   <= act_t'(wr_data_i[3:0]);
        RG_CMPA: cmp_a_o <= wr_data_i;
        RG_CMPB: cmp_b_o <= wr_data_i;
        default: ;
      endcase
    end
  end

  // sticky flags: set wins; clear needs a prior read of 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      arm_q  <= '0;
    end else begin
      for (int i = 0; i < NF; i++) begin
        if (set_v[i])                           flag_q[i] <= 1'b1;
        else if (wr_stat && !wbit[i] && arm_q[i]) flag_q[i] <= 1'b0;
        if (wr_stat)                            arm_q[i] <= 1'b0;
        else if (rd_stat && flag_q[i])          arm_q[i] <= 1'b1;
      end
    end
  end

  assign flag_a_o = flag_q[0];
  assign flag_b_o = flag_q[1];

  always_comb begin
    rd_data_o = '0;
    unique case (rd_sel_i)
      RG_CTRL: rd_data_o[5:0] = ctrl_o;
      RG_STAT: begin
        rd_data_o[3:0]              = act_o;
        rd_data_o[FLAG_LSB +: NF]   = flag_q;
      end
      RG_CNT:  rd_data_o = cnt_i;
      RG_CMPA: rd_data_o = cmp_a_o;
      RG_CMPB: rd_data_o = cmp_b_o;
      default: ;
    endcase
  end
endmodule

// File: rtl/tmr_pin.sv
module tmr_pin
  import tmr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_a_i,
  input  logic hit_b_i,
  input  act_t act_i,
  output logic pin_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pin_o <= 1'b0;
    else if (hit_a_i) pin_o <= pin_next(pin_o, act_i.act_a);
    else if (hit_b_i) pin_o <= pin_next(pin_o, act_i.act_b);
  end
endmodule

// File: rtl/tmr_pair_top.sv
module tmr_pair_top
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       tick_i,
  input  logic             ext_clr_i,
  input  logic             wr_en_i,
  input  logic [SEL_W:0]   wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic [SEL_W:0]   rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic [1:0]       pin_o
);
  localparam int unsigned W2 = 2 * CNT_W;

  ctrl_t            ctrl   [N_CH];
  act_t             act    [N_CH];
  logic [CNT_W-1:0] cmp_a  [N_CH];
  logic [CNT_W-1:0] cmp_b  [N_CH];
  logic [CNT_W-1:0] cnt_q  [N_CH];
  logic [CNT_W-1:0] cnt_d  [N_CH];
  logic [CNT_W-1:0] rd_ch  [N_CH];
  logic [N_CH-1:0]  flag_a, flag_b, hit8_a, hit8_b, hit_a, hit_b;
  logic [N_CH-1:0]  cnt_wr, clr_ch, step;
  logic             hit16_a, hit16_b, mode16, mcnt;
  logic [W2-1:0]    cat_inc;

  assign mode16 = (ctrl[0].clk_sel == CS_LINK);
  assign mcnt   = !mode16 && (ctrl[1].clk_sel == CS_LINK);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic wr_c, rd_c;
    assign wr_c      = wr_en_i && (wr_addr_i[SEL_W] == 1'(c));
    assign rd_c      = rd_en_i && (rd_addr_i[SEL_W] == 1'(c));
    assign cnt_wr[c] = wr_c && (wr_addr_i[SEL_W-1:0] == RG_CNT);

    tmr_regs #(.CNT_W(CNT_W)) i_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_c),
      .wr_sel_i (wr_addr_i[SEL_W-1:0]),
      .wr_data_i(wr_data_i),
      .rd_en_i  (rd_c),
      .rd_sel_i (rd_addr_i[SEL_W-1:0]),
      .cnt_i    (cnt_q[c]),
      .set_a_i  (hit_a[c]),
      .set_b_i  (hit_b[c]),
      .ctrl_o   (ctrl[c]),
      .act_o    (act[c]),
      .cmp_a_o  (cmp_a[c]),
      .cmp_b_o  (cmp_b[c]),
      .flag_a_o (flag_a[c]),
      .flag_b_o (flag_b[c]),
      .rd_data_o(rd_ch[c])
    );

    tmr_cmp #(.W(CNT_W)) i_cmp_a (
      .clk_i(clk_i), .rst_ni(rst_ni), .val_i(cnt_q[c]), .ref_i(cmp_a[c]), .hit_o(hit8_a[c])
    );
    tmr_cmp #(.W(CNT_W)) i_cmp_b (
      .clk_i(clk_i), .rst_ni(rst_ni), .val_i(cnt_q[c]), .ref_i(cmp_b[c]), .hit_o(hit8_b[c])
    );

    tmr_pin i_pin (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hit_a_i(hit_a[c]),
      .hit_b_i(hit_b[c]),
      .act_i  (act[c]),
      .pin_o  (pin_o[c])
    );

    assign clr_ch[c] = clr_hit(ctrl[c], hit_a[c], hit_b[c], ext_clr_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q[c] <= '0;
      else         cnt_q[c] <= cnt_d[c];
    end
  end

  tmr_cmp #(.W(W2)) i_cmp16_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .val_i({cnt_q[0], cnt_q[1]}),
    .ref_i({cmp_a[0], cmp_a[1]}), .hit_o(hit16_a)
  );
  tmr_cmp #(.W(W2)) i_cmp16_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .val_i({cnt_q[0], cnt_q[1]}),
    .ref_i({cmp_b[0], cmp_b[1]}), .hit_o(hit16_b)
  );

  // channel 0 sees 16-bit events when linked; channel 1 always sees its own byte
  assign hit_a[0] = mode16 ? hit16_a : hit8_a[0];
  assign hit_b[0] = mode16 ? hit16_b : hit8_b[0];
  assign hit_a[1] = hit8_a[1];
  assign hit_b[1] = hit8_b[1];

  assign step[0] = sel_tick(ctrl[0].clk_sel, tick_i);
  assign step[1] = mcnt ? hit_a[0] : sel_tick(ctrl[1].clk_sel, tick_i);
  assign cat_inc = {cnt_q[0], cnt_q[1]} + W2'(1);

  always_comb begin
    for (int c = 0; c < N_CH; c++) cnt_d[c] = cnt_q[c];
    if (mode16) begin
      if (clr_ch[0])      {cnt_d[0], cnt_d[1]} = '0;
      else if (tick_i[0]) {cnt_d[0], cnt_d[1]} = cat_inc;
    end else begin
      for (int c = 0; c < N_CH; c++) begin
        if (clr_ch[c])    cnt_d[c] = '0;
        else if (step[c]) cnt_d[c] = cnt_q[c] + CNT_W'(1);
      end
    end
    for (int c = 0; c < N_CH; c++) begin
      if (cnt_wr[c]) cnt_d[c] = wr_data_i;
    end
  end

  assign rd_data_o = rd_ch[rd_addr_i[SEL_W]];
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode16_i,
  input logic             mcnt_i,
  input logic             wr_en_i,
  input logic             stat0_wr_i,
  input logic [2:0]       clk_sel0_i,
  input logic             ext_clr_i,
  input logic [CNT_W-1:0] cnt_hi_i,
  input logic [CNT_W-1:0] cnt_lo_i,
  input logic             flag_a0_i,
  input logic             flag_b0_i,
  input logic             flag_a1_i,
  input logic             flag_b1_i,
  input logic [1:0]       pin_i
);
  p_pin0_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pin_i[0]) |-> (flag_a0_i || flag_b0_i));

  p_pin1_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pin_i[1]) |-> (flag_a1_i || flag_b1_i));

  p_flag_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_a0_i |=> (flag_a0_i || $past(stat0_wr_i)));

  p_stopped_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode16_i && clk_sel0_i == 3'b000 && !wr_en_i && !ext_clr_i)
    |=> (cnt_hi_i == $past(cnt_hi_i) || cnt_hi_i == '0));

  p_lo_not_alone_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode16_i && !wr_en_i && cnt_lo_i != '0 && cnt_lo_i != '1)
    |=> (cnt_lo_i != '0 || cnt_hi_i == '0));

  p_count_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mcnt_i && !wr_en_i && cnt_lo_i != '1)
    |=> (cnt_lo_i != $past(cnt_lo_i) + CNT_W'(1) || flag_a0_i));
endmodule

bind tmr_pair_top tmr_pair_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode16_i  (mode16),
  .mcnt_i    (mcnt),
  .wr_en_i   (wr_en_i),
  .stat0_wr_i(wr_en_i && (wr_addr_i == {1'b0, tmr_pkg::RG_STAT})),
  .clk_sel0_i(ctrl[0].clk_sel),
  .ext_clr_i (ext_clr_i),
  .cnt_hi_i  (cnt_q[0]),
  .cnt_lo_i  (cnt_q[1]),
  .flag_a0_i (flag_a[0]),
  .flag_b0_i (flag_b[0]),
  .flag_a1_i (flag_a[1]),
  .flag_b1_i (flag_b[1]),
  .pin_i     (pin_o)
);

// File: tb/test_tmr_pair_top.sv
module test_tmr_pair_top;
  import tmr_pkg::*;
  localparam int unsigned CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       tick_i = '0;
  logic             ext_clr_i = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [SEL_W:0]   wr_addr_i = '0;
  logic [CNT_W-1:0] wr_data_i = '0;
  logic             rd_en_i = 1'b0;
  logic [SEL_W:0]   rd_addr_i = '0;
  logic [CNT_W-1:0] rd_data_o;
  logic [1:0]       pin_o;

  always #4 clk = ~clk;

  tmr_pair_top #(.CNT_W(CNT_W)) i_tmr_pair_top (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .ext_clr_i(ext_clr_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .pin_o(pin_o)
  );

  typedef struct {
    bit               is_pin;
    logic [SEL_W:0]   addr;
    logic [CNT_W-1:0] exp;
    string            tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  // monitor: pops expected items and compares them mid-cycle
  initial forever begin
    @(negedge clk);
    #2;
    while (q.size() > 0) begin
      exp_t it;
      logic [CNT_W-1:0] got;
      it  = q.pop_front();
      got = it.is_pin ? CNT_W'(pin_o) : rd_data_o;
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s addr=%0h actual=%0h expected=%0h", it.tag, it.addr, got, it.exp);
      end
    end
  end

  // all tasks are entered right after a falling edge
  task automatic chk_reg(input logic [SEL_W:0] a, input logic [CNT_W-1:0] e, input string tag);
    exp_t it;
    rd_addr_i = a;
    it.is_pin = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk_pin(input logic [1:0] e, input string tag);
    exp_t it;
    it.is_pin = 1'b1; it.addr = '0; it.exp = CNT_W'(e); it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [SEL_W:0] a, input logic [CNT_W-1:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_pulse(input logic [SEL_W:0] a);
    rd_en_i = 1'b1; rd_addr_i = a;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic tick(input int n);
    tick_i = 2'b01;
    repeat (n) @(negedge clk);
    tick_i = 2'b00;
    @(negedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    chk_reg(4'h0, 8'h00, "R1 ctrl0");
    chk_reg(4'h1, 8'h00, "R1 stat0");
    chk_reg(4'h2, 8'h00, "R1 cnt0");
    chk_reg(4'hA, 8'h00, "R1 cnt1");
    chk_pin(2'b00, "R1 pins");

    // normal mode, events and pin actions
    wr(4'h0, 8'h01); wr(4'h3, 8'd5); wr(4'h4, 8'd3); wr(4'h1, 8'h09);
    tick(3);
    chk_reg(4'h2, 8'd3, "R2 count on tick0");
    chk_reg(4'h1, 8'h89, "R3 flag B set");
    chk_pin(2'b01, "R6 B drives high");
    tick(2);
    chk_reg(4'h1, 8'hC9, "R3 flag A set");
    chk_pin(2'b00, "R6 A drives low");
    wr(4'h1, 8'h09);
    chk_reg(4'h1, 8'hC9, "R4 write without read ignored");
    rd_pulse(4'h1);
    wr(4'h1, 8'h09);
    chk_reg(4'h1, 8'h09, "R4 read then write clears");

    // A over B priority
    do_reset();
    wr(4'h0, 8'h01); wr(4'h3, 8'd2); wr(4'h4, 8'd2); wr(4'h1, 8'h09);
    tick(2);
    chk_pin(2'b00, "R6 A priority");
    chk_reg(4'h1, 8'hC9, "R3 both flags");

    // clear on compare A
    do_reset();
    wr(4'h0, 8'h09); wr(4'h3, 8'd4); wr(4'h4, 8'h80);
    tick(4);
    chk_reg(4'h2, 8'd0, "R5 clear on A");
    chk_reg(4'h1, 8'h40, "R5 flag A with clear");

    // external clear on channel 1
    do_reset();
    wr(4'h8, 8'h21);
    tick(5);
    chk_reg(4'hA, 8'd5, "R2 ch1 count");
    ext_clr_i = 1'b1; @(negedge clk); ext_clr_i = 1'b0;
    chk_reg(4'hA, 8'd0, "R5 external clear");

    // 16-bit carry and wrap
    do_reset();
    wr(4'h0, 8'h04); wr(4'h8, 8'h08); wr(4'h2, 8'h00); wr(4'hA, 8'hFE);
    chk_reg(4'hA, 8'hFE, "R12 count write");
    tick(3);
    chk_reg(4'h2, 8'h01, "R7 carry into high byte");
    chk_reg(4'hA, 8'h01, "R7 low byte after carry");
    wr(4'h2, 8'hFF); wr(4'hA, 8'hFF);
    tick(1);
    chk_reg(4'h2, 8'h00, "R7 wrap high");
    chk_reg(4'hA, 8'h00, "R7 wrap low");

    // 16-bit compare, split flags, clear and pins
    do_reset();
    wr(4'h0, 8'h2C); wr(4'h8, 8'h08); wr(4'h3, 8'h01); wr(4'h4, 8'h80);
    wr(4'hB, 8'h03); wr(4'h1, 8'h03); wr(4'h9, 8'h02);
    tick(3);
    chk_reg(4'hA, 8'h03, "R9 low clear ignored");
    chk_reg(4'h9, 8'h42, "R8 low byte flag");
    chk_reg(4'h1, 8'h03, "R8 no 16-bit flag yet");
    chk_pin(2'b10, "R10 pin1 on low match");
    wr(4'h2, 8'h01);
    idle();
    chk_reg(4'h2, 8'h00, "R9 16-bit clear high");
    chk_reg(4'hA, 8'h00, "R9 16-bit clear low");
    chk_reg(4'h1, 8'h43, "R8 16-bit flag");
    chk_pin(2'b11, "R10 pin0 toggles");

    // compare-match count mode
    do_reset();
    wr(4'h0, 8'h09); wr(4'h3, 8'd2); wr(4'h4, 8'h80);
    wr(4'h8, 8'h04); wr(4'hB, 8'd2); wr(4'h9, 8'h02);
    tick(2);
    tick(2);
    idle();
    chk_reg(4'hA, 8'd2, "R11 counts ch0 A events");
    chk_reg(4'h9, 8'h42, "R11 ch1 own flag");
    chk_pin(2'b10, "R11 ch1 own pin");
    chk_reg(4'h2, 8'd0, "R11 ch0 own clear");
    chk_reg(4'h1, 8'h40, "R11 ch0 own flag");

    @(negedge clk);
    #3;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule